// File: doc/BRIEF.md
# Three-Operand Cascadable DSP ALU

This block is the arithmetic and logic stage that sits behind the multipliers of a DSP slice. It takes two operands, A and B, that have already been multiplied or passed around the multipliers, and a third operand, C. In arithmetic mode it forms A plus or minus B plus or minus C over a 54-bit signed datapath, and the sign of each term is chosen separately. In logic mode it forms a bitwise function of B and C only. Because the multipliers can be bypassed, the block also serves as a plain wide adder.

A carry input is added at the least significant bit, and a carry output taken above the most significant bit lets neighbouring slices chain into wider adders or adder trees. The block has three register stages: an input stage, a pipeline stage after the ALU, and an output stage. Each stage can be switched into or out of the path, so the latency can be set anywhere from zero to three cycles. Two status flags, result-is-zero and result-matches-pattern, move through the output stage together with the result.

Top module: `dsp_alu3`

## Requirements
- R1: With op_i[2]=0 the result is A + B + C modulo 2^54. Setting op_i[0]=1 subtracts B instead of adding it, and setting op_i[1]=1 subtracts C instead of adding it.
- R2: In arithmetic mode cin_i is added at bit 0 of the sum.
- R3: In arithmetic mode cout_o is bit 54 of the unsigned sum A + B' + C' + cin, where a subtracted operand X contributes ~X + 1 and an added one contributes X.
- R4: With op_i[2]=1 the result is B AND C for op_i[1:0]=00, B OR C for 01, B XOR C for 10 and B XNOR C for 11. In this mode a_i and cin_i have no effect and cout_o is 0.
- R5: zero_o is 1 exactly when the result presented with it is all zeros.
- R6: pat_hit_o is 1 exactly when the result presented with it equals pat_i. pat_i is held static.
- R7: The flags are captured by the output stage in the same cycle as the result. With the output stage bypassed, they follow the result combinationally.
- R8: The latency from the operand inputs to r_o equals the number of the enables cfg_in_reg_i, cfg_pipe_reg_i and cfg_out_reg_i that are set, from 0 to 3 cycles.
- R9: A synchronous active-low reset clears every stage register. With the output stage enabled, r_o, cout_o, zero_o and pat_hit_o all read 0 on the cycle after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_in_reg_i | input | 1 | 1 places the input register stage in the path |
| cfg_pipe_reg_i | input | 1 | 1 places the pipeline register stage in the path |
| cfg_out_reg_i | input | 1 | 1 places the output register stage in the path |
| op_i | input | 3 | [2] logic mode; [1:0] subtract selects or logic function |
| a_i | input | 54 | Operand A (multiplier product or bypass) |
| b_i | input | 54 | Operand B (multiplier product or bypass) |
| c_i | input | 54 | Operand C |
| cin_i | input | 1 | Carry in from the previous slice |
| pat_i | input | 54 | Compare value for the pattern flag |
| r_o | output | 54 | Result |
| cout_o | output | 1 | Carry out to the next slice |
| zero_o | output | 1 | Result is zero |
| pat_hit_o | output | 1 | Result equals pat_i |

## Verification
The hardest cases to reach from the ports are the carry output when both B and C are subtracted, because the sum can then wrap past 2^54 twice, and the exact cycle at which a result appears under each mix of stage enables. Vectors are chosen so that the double wrap gives both carry values, and so that an all-ones operand plus one forces a carry. The latency sweep first flushes the pipe with zeros. It then applies a single vector and samples r_o and the flags after every edge, expecting the value to switch exactly when the number of enabled stages has elapsed.

// File: rtl/dsp_alu3_pkg.sv
// Package: shared opcode layout and logic-function codes for the DSP ALU.
// Assumes op bit 2 selects the mode and bits 1:0 carry the mode-specific field.
package dsp_alu3_pkg;
    localparam int OPW = 3;

    typedef enum logic [1:0] {
        LF_AND  = 2'b00,
        LF_OR   = 2'b01,
        LF_XOR  = 2'b10,
        LF_XNOR = 2'b11
    } lfunc_e;

    // sel[0]: subtract B, sel[1]: subtract C (arithmetic); logic function code (logic)
    typedef struct packed {
        logic       logic_mode;
        logic [1:0] sel;
    } op_t;
endpackage

// File: rtl/dsp_alu3_stage.sv
// Bypassable register stage: when en is set the output is the registered
// copy of d, otherwise d passes straight through. Assumes en is quasi-static.
module dsp_alu3_stage #(
    parameter int WD = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [WD-1:0] d,
    output logic [WD-1:0] q
);
    logic [WD-1:0] r;

    // Capture the stage input every cycle; synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) r <= '0;
        else        r <= d;
    end

    // Select registered or pass-through path
    always_comb q = en ? r : d;
endmodule

// File: rtl/dsp_alu3_core.sv
// Combinational ALU: A +/- B +/- C + cin in arithmetic mode, bitwise B/C
// function in logic mode. Carry out is bit W of the full sum; 0 in logic mode.
module dsp_alu3_core
    import dsp_alu3_pkg::*;
#(
    parameter int W = 54
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  op_t          op,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int SW = W + 2;

    logic [W-1:0]  bx, cx;
    logic [SW-1:0] sum;

    // Two's-complement conditioning of B and C and the three-term sum
    always_comb begin
        bx  = op.sel[0] ? ~b : b;
        cx  = op.sel[1] ? ~c : c;
        sum = {2'b00, a} + {2'b00, bx} + {2'b00, cx}
            + SW'(op.sel[0]) + SW'(op.sel[1]) + SW'(cin);
    end

    // Mode select and logic-function decode
    always_comb begin
        if (op.logic_mode) begin
            cout = 1'b0;
            unique case (lfunc_e'(op.sel))
                LF_AND:  res = b & c;
                LF_OR:   res = b | c;
                LF_XOR:  res = b ^ c;
                default: res = ~(b ^ c);
            endcase
        end else begin
            res  = sum[W-1:0];
            cout = sum[W];
        end
    end
endmodule

// File: rtl/dsp_alu3_flags.sv
// Status flag generator: zero detect and equality against a compare value.
// Assumes the compare value is held static while results are in flight.
module dsp_alu3_flags #(
    parameter int W = 54
) (
    input  logic [W-1:0] res,
    input  logic [W-1:0] pat,
    output logic         zero,
    output logic         hit
);
    // Compare the result against zero and the pattern
    always_comb begin
        zero = (res == '0);
        hit  = (res == pat);
    end
endmodule

// File: rtl/dsp_alu3.sv
// Three-operand cascadable DSP ALU. Input stage -> ALU -> pipeline stage ->
// flags -> output stage; each stage is bypassable via a cfg enable.
// Assumes cfg enables and pat_i are static during operation.
module dsp_alu3
    import dsp_alu3_pkg::*;
#(
    parameter int W = 54
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_in_reg_i,
    input  logic         cfg_pipe_reg_i,
    input  logic         cfg_out_reg_i,
    input  logic [2:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    input  logic         cin_i,
    input  logic [W-1:0] pat_i,
    output logic [W-1:0] r_o,
    output logic         cout_o,
    output logic         zero_o,
    output logic         pat_hit_o
);
    localparam int S1W = 3 * W + OPW + 1;
    localparam int S2W = W + 1;
    localparam int S3W = W + 3;

    logic [S1W-1:0] s1_d, s1_q;
    logic [W-1:0]   s1_a, s1_b, s1_c;
    logic [OPW-1:0] s1_op;
    logic           s1_cin;
    logic [W-1:0]   alu_res;
    logic           alu_cout;
    logic [S2W-1:0] s2_q;
    logic [W-1:0]   p2_res;
    logic           p2_cout;
    logic           fl_zero, fl_hit;
    logic [S3W-1:0] s3_q;

    // Bundle the operand inputs for the input stage
    always_comb s1_d = {a_i, b_i, c_i, op_i, cin_i};

    dsp_alu3_stage #(.WD(S1W)) in_stage_i (
        .clk(clk), .rst_n(rst_n), .en(cfg_in_reg_i), .d(s1_d), .q(s1_q)
    );

    // Unbundle the input-stage output
    always_comb {s1_a, s1_b, s1_c, s1_op, s1_cin} = s1_q;

    dsp_alu3_core #(.W(W)) core_i (
        .a(s1_a), .b(s1_b), .c(s1_c), .op(op_t'(s1_op)), .cin(s1_cin),
        .res(alu_res), .cout(alu_cout)
    );

    dsp_alu3_stage #(.WD(S2W)) pipe_stage_i (
        .clk(clk), .rst_n(rst_n), .en(cfg_pipe_reg_i),
        .d({alu_cout, alu_res}), .q(s2_q)
    );

    // Unbundle the pipeline-stage output
    always_comb {p2_cout, p2_res} = s2_q;

    dsp_alu3_flags #(.W(W)) flags_i (
        .res(p2_res), .pat(pat_i), .zero(fl_zero), .hit(fl_hit)
    );

    dsp_alu3_stage #(.WD(S3W)) out_stage_i (
        .clk(clk), .rst_n(rst_n), .en(cfg_out_reg_i),
        .d({fl_hit, fl_zero, p2_cout, p2_res}), .q(s3_q)
    );

    // Drive the result and flag ports from the output stage
    always_comb {pat_hit_o, zero_o, cout_o, r_o} = s3_q;
endmodule

// File: rtl/dsp_alu3_chk.sv
// Property checker for dsp_alu3, attached by bind. Observes ports and the
// signals passed between the ALU core and the register stages.
module dsp_alu3_chk #(
    parameter int W = 54
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_in_reg_i,
    input logic         cfg_pipe_reg_i,
    input logic         cfg_out_reg_i,
    input logic [2:0]   s1_op,
    input logic [W-1:0] s1_b,
    input logic [W-1:0] alu_res,
    input logic         alu_cout,
    input logic [W-1:0] p2_res,
    input logic [W-1:0] pat_i,
    input logic [W-1:0] r_o,
    input logic         zero_o,
    input logic         pat_hit_o
);
    // R4
    logic_cout_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_op[2] |-> !alu_cout);

    // R4
    logic_and_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_op == 3'b100) |-> ((alu_res & ~s1_b) == '0));

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o |-> (r_o == '0));

    // R6
    pat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pat_hit_o |-> (r_o == pat_i));

    // R7
    out_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_out_reg_i && $past(cfg_out_reg_i) && $past(rst_n))
        |-> (r_o == $past(p2_res)) && (zero_o == ($past(p2_res) == '0)));

    // R8
    full_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_in_reg_i && !cfg_pipe_reg_i && !cfg_out_reg_i) |-> (r_o == alu_res));

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && cfg_out_reg_i) |-> (r_o == '0) && !zero_o && !pat_hit_o);
endmodule

bind dsp_alu3 dsp_alu3_chk #(.W(W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_in_reg_i(cfg_in_reg_i), .cfg_pipe_reg_i(cfg_pipe_reg_i),
    .cfg_out_reg_i(cfg_out_reg_i),
    .s1_op(s1_op), .s1_b(s1_b), .alu_res(alu_res), .alu_cout(alu_cout),
    .p2_res(p2_res), .pat_i(pat_i), .r_o(r_o), .zero_o(zero_o),
    .pat_hit_o(pat_hit_o)
);

// File: tb/dsp_alu3_tb_top.sv
// Testbench for dsp_alu3: vector table at full latency, then latency sweep,
// mid-run reset and initial reset checks.
module dsp_alu3_tb_top;
    localparam int W  = 54;
    localparam int NV = 11;
    localparam logic [W-1:0] PAT = 54'd21;

    typedef struct packed {
        logic [2:0]   op;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] c;
        logic         cin;
        logic [W-1:0] er;
        logic         ecout;
        logic         ezero;
        logic         ehit;
    } vec_t;

    // op[2] logic mode; arith op[0] sub B, op[1] sub C; logic 00 AND 01 OR 10 XOR 11 XNOR
    localparam vec_t VEC [NV] = '{
        '{3'b000, 54'd5, 54'd7, 54'd9, 1'b0, 54'd21, 1'b0, 1'b0, 1'b1},
        '{3'b000, 54'h3FFFFFFFFFFFFF, 54'd1, 54'd0, 1'b1, 54'd1, 1'b1, 1'b0, 1'b0},
        '{3'b001, 54'd100, 54'd30, 54'd5, 1'b0, 54'd75, 1'b1, 1'b0, 1'b0},
        '{3'b010, 54'd3, 54'd4, 54'd10, 1'b0, 54'h3FFFFFFFFFFFFD, 1'b0, 1'b0, 1'b0},
        '{3'b011, 54'd10, 54'd3, 54'd2, 1'b0, 54'd5, 1'b0, 1'b0, 1'b0},
        '{3'b011, 54'd0, 54'd1, 54'd1, 1'b0, 54'h3FFFFFFFFFFFFE, 1'b1, 1'b0, 1'b0},
        '{3'b100, 54'h123456, 54'hF0F0, 54'hFF00, 1'b1, 54'hF000, 1'b0, 1'b0, 1'b0},
        '{3'b101, 54'h123456, 54'hF0F0, 54'hFF00, 1'b1, 54'hFFF0, 1'b0, 1'b0, 1'b0},
        '{3'b110, 54'h123456, 54'hF0F0, 54'hFF00, 1'b1, 54'h0FF0, 1'b0, 1'b0, 1'b0},
        '{3'b111, 54'h123456, 54'hF0F0, 54'hFF00, 1'b1, 54'h3FFFFFFFFFF00F, 1'b0, 1'b0, 1'b0},
        '{3'b001, 54'd7, 54'd7, 54'd0, 1'b0, 54'd0, 1'b1, 1'b1, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cfg_in, cfg_pipe, cfg_out;
    logic [2:0]   op;
    logic [W-1:0] a, b, c, pat;
    logic         cin;
    logic [W-1:0] r;
    logic         cout, zero, hit;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dsp_alu3 #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_in_reg_i(cfg_in), .cfg_pipe_reg_i(cfg_pipe), .cfg_out_reg_i(cfg_out),
        .op_i(op), .a_i(a), .b_i(b), .c_i(c), .cin_i(cin), .pat_i(pat),
        .r_o(r), .cout_o(cout), .zero_o(zero), .pat_hit_o(hit)
    );

    task automatic check(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op = v.op; a = v.a; b = v.b; c = v.c; cin = v.cin;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        cfg_in = 1'b1; cfg_pipe = 1'b1; cfg_out = 1'b1;
        op = '0; a = '0; b = '0; c = '0; cin = 1'b0; pat = PAT;
        repeat (2) @(posedge clk);
        #2;
        // R9 reset state
        check("R9 reset r_o", r, '0);
        check("R9 reset cout_o", W'(cout), '0);
        check("R9 reset zero_o", W'(zero), '0);
        check("R9 reset pat_hit_o", W'(hit), '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk at latency 3: R1 R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            repeat (3) @(posedge clk);
            #2;
            check($sformatf("R1 R2 R4 vector %0d r_o", i), r, VEC[i].er);
            check($sformatf("R3 R4 vector %0d cout_o", i), W'(cout), W'(VEC[i].ecout));
            check($sformatf("R5 R7 vector %0d zero_o", i), W'(zero), W'(VEC[i].ezero));
            check($sformatf("R6 R7 vector %0d pat_hit_o", i), W'(hit), W'(VEC[i].ehit));
        end

        // R8 latency sweep over stage enables (R7 flags follow the result)
        for (int m = 0; m < 4; m++) begin
            int lat;
            logic [2:0] cf;
            cf  = (m == 0) ? 3'b000 : (m == 1) ? 3'b100 : (m == 2) ? 3'b011 : 3'b111;
            lat = m;
            @(negedge clk);
            {cfg_in, cfg_pipe, cfg_out} = cf;
            op = 3'b000; a = '0; b = '0; c = '0; cin = 1'b0;
            repeat (4) @(posedge clk);
            @(negedge clk);
            drive(VEC[0]);
            for (int k = 0; k < 4; k++) begin
                if (k > 0) @(posedge clk);
                #2;
                check($sformatf("R8 cfg %b edge %0d r_o", cf, k), r, (k >= lat) ? PAT : '0);
                check($sformatf("R7 cfg %b edge %0d zero_o", cf, k), W'(zero), W'(k < lat));
                check($sformatf("R7 cfg %b edge %0d pat_hit_o", cf, k), W'(hit), W'(k >= lat));
            end
        end

        // R9 mid-run reset with all stages enabled, then refill in 3 cycles (R8)
        @(negedge clk);
        {cfg_in, cfg_pipe, cfg_out} = 3'b111;
        drive(VEC[1]);
        repeat (4) @(posedge clk);
        #2;
        check("R2 R3 before reset cout_o", W'(cout), W'(1));
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check("R9 mid reset r_o", r, '0);
        check("R9 mid reset cout_o", W'(cout), '0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R8 refill r_o", r, 54'd1);

        finish_run();
    end
endmodule